// File: doc/BRIEF.md
# Integer ALU with Status Flags

This block is the integer execution unit of a small RISC-style core. It is purely combinational. From an operation select, two 32-bit register operands (`srcA`, `srcB`), a 16-bit immediate field and the current status flags, it produces a 32-bit result and a new flag word. It also drives a per-flag write-enable, so the core's status register can update only the flags the operation owns.

The supported operations fall into five groups:

- add and the two subtract forms;
- halfword multiply;
- moves, including a register-plus-immediate move and an add of an immediate placed in the upper half;
- the four bitwise operations;
- three shifts.

Immediate forms always combine the immediate with `srcB`. The 5-bit forms read `imm[4:0]` only. The 16-bit forms read all of `imm`. Each operation has its own sign or zero extension. The flag word packs zero in bit 0, sign in bit 1, overflow in bit 2 and carry in bit 3.

Top module: `int_alu`

## Requirements
- R1: Opcode codes are ADD=0, ADDI5=1, ADDI16=2, SUB=3, SUBR=4, MULH=5, MULHI5=6, MULHI16=7, MOV=8, MOVI5=9, MOVEA=10, MOVHI=11, OR=12, ORI=13, AND=14, ANDI=15, XOR=16, XORI=17, NOT=18, SAR=19, SARI=20, SHR=21, SHRI=22, SHL=23, SHLI=24. ADD gives srcA+srcB, SUB gives srcB−srcA and SUBR gives srcA−srcB, all modulo 2^32.
- R2: ADDI5 gives srcB plus imm[4:0] sign-extended, and ADDI16 gives srcB plus imm sign-extended. imm bits 15..5 have no effect on any 5-bit form.
- R3: ADD, ADDI5 and ADDI16 raise all four flag write-enables (flagWe=4'b1111). The new flags are:
  - zero (bit 0) = result equals 0;
  - sign (bit 1) = result bit 31;
  - overflow (bit 2) = both addends share bit 31 and the result's bit 31 differs from it;
  - carry (bit 3) = the unsigned sum exceeds 2^32−1.
- R4: OR, ORI, AND, ANDI, XOR, XORI and NOT set flagWe=4'b0111. They set zero and sign from the result and drive overflow to 0. Carry keeps its input value.
- R5: All other opcodes, defined or not, set flagWe=0 and flagsOut equal to flagsIn.
- R6: MULH gives srcB[15:0]×srcA[15:0] unsigned. MULHI5 gives srcB[15:0]×(imm[4:0] sign-extended), truncated to 32 bits. MULHI16 gives srcB[15:0]×imm, unsigned.
- R7: MOV gives srcA and MOVI5 gives imm[4:0] sign-extended. MOVEA gives srcB plus imm sign-extended. MOVHI gives srcB plus imm shifted left by 16.
- R8: OR, AND and XOR combine srcB with srcA. ORI, ANDI and XORI combine srcB with imm zero-extended. NOT gives the complement of srcA.
- R9: SAR, SHR and SHL shift srcB by srcA[4:0]. SARI, SHRI and SHLI shift srcB by imm[4:0]. SAR fills with bit 31, SHR fills with zeros, SHL shifts in zeros. An amount of 0 leaves srcB unchanged.
- R10: Opcodes 25 to 31 give a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 5 | Operation code |
| srcA | input | 32 | First register operand |
| srcB | input | 32 | Second register operand; the register operand of every immediate form |
| imm | input | 16 | Immediate field; 5-bit forms use bits 4..0 |
| flagsIn | input | 4 | Current flags {carry, overflow, sign, zero} |
| result | output | 32 | Operation result |
| flagsOut | output | 4 | New flag values; unwritten flags pass through |
| flagWe | output | 4 | Per-flag write-enable, same bit order |

## Verification
No register lies between any input and any output, so the result, the flags and the write-enables are all due in the same cycle as the stimulus. The bench drives a new vector on each falling clock edge. It samples the outputs a quarter period later, well before the next rising edge, so no sample depends on the order of processes at an edge. The sweep covers every opcode against a fixed set of corner operand pairs, several immediates and several incoming flag patterns. Among the operand pairs are 0x7FFFFFFF+1, 0xFFFFFFFF+1, shift amounts 0 and 31, and the 5-bit immediate 0x10.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  localparam int DATA_W     = 32;
  localparam int IMM_NARROW = 5;
  localparam int IMM_WIDE   = 16;
  localparam int HALF_W     = DATA_W / 2;
  localparam int SHAMT_W    = $clog2(DATA_W);
  localparam int OP_W       = 5;
  localparam int FLAG_N     = 4;

  localparam int FLAG_Z  = 0;
  localparam int FLAG_S  = 1;
  localparam int FLAG_OV = 2;
  localparam int FLAG_CY = 3;

  localparam logic [FLAG_N-1:0] WE_ALL   = 4'b1111;
  localparam logic [FLAG_N-1:0] WE_LOGIC = 4'b0111;

  typedef enum logic [OP_W-1:0] {
    OP_ADD     = 5'd0,  OP_ADDI5 = 5'd1,  OP_ADDI16 = 5'd2,
    OP_SUB     = 5'd3,  OP_SUBR  = 5'd4,
    OP_MULH    = 5'd5,  OP_MULHI5 = 5'd6, OP_MULHI16 = 5'd7,
    OP_MOV     = 5'd8,  OP_MOVI5 = 5'd9,  OP_MOVEA = 5'd10, OP_MOVHI = 5'd11,
    OP_OR      = 5'd12, OP_ORI   = 5'd13, OP_AND   = 5'd14, OP_ANDI  = 5'd15,
    OP_XOR     = 5'd16, OP_XORI  = 5'd17, OP_NOT   = 5'd18,
    OP_SAR     = 5'd19, OP_SARI  = 5'd20, OP_SHR   = 5'd21, OP_SHRI  = 5'd22,
    OP_SHL     = 5'd23, OP_SHLI  = 5'd24
  } opSel_e;

  typedef enum logic [2:0] {
    SRC_REG, SRC_NARROW_S, SRC_NARROW_Z, SRC_WIDE_S, SRC_WIDE_Z, SRC_WIDE_HI
  } srcSel_e;

  typedef enum logic [3:0] {
    UNIT_NONE, UNIT_ADD, UNIT_SUB_BA, UNIT_SUB_AB, UNIT_MUL, UNIT_PASS,
    UNIT_OR, UNIT_AND, UNIT_XOR, UNIT_NOT, UNIT_SAR, UNIT_SHR, UNIT_SHL
  } unit_e;

  typedef struct packed {
    unit_e             unit;
    srcSel_e           srcSel;
    logic [FLAG_N-1:0] flagWe;
    logic              ovClear;
  } aluCtrl_t;
endpackage

// File: rtl/int_alu_ctrl.sv
module int_alu_ctrl
  import int_alu_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output aluCtrl_t        ctrl
);
  always_comb begin
    ctrl.unit    = UNIT_NONE;
    ctrl.srcSel  = SRC_REG;
    ctrl.flagWe  = '0;
    ctrl.ovClear = 1'b0;
    case (opSel)
      OP_ADD:     begin ctrl.unit = UNIT_ADD; ctrl.flagWe = WE_ALL; end
      OP_ADDI5:   begin ctrl.unit = UNIT_ADD; ctrl.srcSel = SRC_NARROW_S; ctrl.flagWe = WE_ALL; end
      OP_ADDI16:  begin ctrl.unit = UNIT_ADD; ctrl.srcSel = SRC_WIDE_S; ctrl.flagWe = WE_ALL; end
      OP_SUB:     ctrl.unit = UNIT_SUB_BA;
      OP_SUBR:    ctrl.unit = UNIT_SUB_AB;
      OP_MULH:    ctrl.unit = UNIT_MUL;
      OP_MULHI5:  begin ctrl.unit = UNIT_MUL; ctrl.srcSel = SRC_NARROW_S; end
      OP_MULHI16: begin ctrl.unit = UNIT_MUL; ctrl.srcSel = SRC_WIDE_Z; end
      OP_MOV:     ctrl.unit = UNIT_PASS;
      OP_MOVI5:   begin ctrl.unit = UNIT_PASS; ctrl.srcSel = SRC_NARROW_S; end
      OP_MOVEA:   begin ctrl.unit = UNIT_ADD; ctrl.srcSel = SRC_WIDE_S; end
      OP_MOVHI:   begin ctrl.unit = UNIT_ADD; ctrl.srcSel = SRC_WIDE_HI; end
      OP_OR:      begin ctrl.unit = UNIT_OR;  ctrl.flagWe = WE_LOGIC; ctrl.ovClear = 1'b1; end
      OP_ORI:     begin ctrl.unit = UNIT_OR;  ctrl.srcSel = SRC_WIDE_Z; ctrl.flagWe = WE_LOGIC; ctrl.ovClear = 1'b1; end
      OP_AND:     begin ctrl.unit = UNIT_AND; ctrl.flagWe = WE_LOGIC; ctrl.ovClear = 1'b1; end
      OP_ANDI:    begin ctrl.unit = UNIT_AND; ctrl.srcSel = SRC_WIDE_Z; ctrl.flagWe = WE_LOGIC; ctrl.ovClear = 1'b1; end
      OP_XOR:     begin ctrl.unit = UNIT_XOR; ctrl.flagWe = WE_LOGIC; ctrl.ovClear = 1'b1; end
      OP_XORI:    begin ctrl.unit = UNIT_XOR; ctrl.srcSel = SRC_WIDE_Z; ctrl.flagWe = WE_LOGIC; ctrl.ovClear = 1'b1; end
      OP_NOT:     begin ctrl.unit = UNIT_NOT; ctrl.flagWe = WE_LOGIC; ctrl.ovClear = 1'b1; end
      OP_SAR:     ctrl.unit = UNIT_SAR;
      OP_SARI:    begin ctrl.unit = UNIT_SAR; ctrl.srcSel = SRC_NARROW_Z; end
      OP_SHR:     ctrl.unit = UNIT_SHR;
      OP_SHRI:    begin ctrl.unit = UNIT_SHR; ctrl.srcSel = SRC_NARROW_Z; end
      OP_SHL:     ctrl.unit = UNIT_SHL;
      OP_SHLI:    begin ctrl.unit = UNIT_SHL; ctrl.srcSel = SRC_NARROW_Z; end
      default:    ctrl.unit = UNIT_NONE;
    endcase
  end

  // R4: bitwise operations never claim the carry flag
  always_comb begin
    if (ctrl.unit inside {UNIT_OR, UNIT_AND, UNIT_XOR, UNIT_NOT})
      a_r4_cy_untouched: assert (!ctrl.flagWe[FLAG_CY] && ctrl.ovClear);
  end
endmodule

// File: rtl/int_alu_datapath.sv
module int_alu_datapath
  import int_alu_pkg::*;
(
  input  aluCtrl_t            ctrl,
  input  logic [DATA_W-1:0]   srcA,
  input  logic [DATA_W-1:0]   srcB,
  input  logic [IMM_WIDE-1:0] imm,
  input  logic [FLAG_N-1:0]   flagsIn,
  output logic [DATA_W-1:0]   result,
  output logic [FLAG_N-1:0]   flagsOut
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] narrowS, narrowZ, wideS, wideZ, wideHi;
  logic [DATA_W-1:0] opnd, mulRight, product;
  logic [DATA_W:0]   sum33;
  logic [DATA_W-1:0] addSum;
  logic              addCarry, addOvf;
  logic [SHAMT_W-1:0] shamt;
  logic [FLAG_N-1:0] newFlag;

  assign narrowS = {{(DATA_W-IMM_NARROW){imm[IMM_NARROW-1]}}, imm[IMM_NARROW-1:0]};
  assign narrowZ = {{(DATA_W-IMM_NARROW){1'b0}}, imm[IMM_NARROW-1:0]};
  assign wideS   = {{(DATA_W-IMM_WIDE){imm[IMM_WIDE-1]}}, imm};
  assign wideZ   = {{(DATA_W-IMM_WIDE){1'b0}}, imm};
  assign wideHi  = {imm, {(DATA_W-IMM_WIDE){1'b0}}};

  always_comb begin
    case (ctrl.srcSel)
      SRC_NARROW_S: opnd = narrowS;
      SRC_NARROW_Z: opnd = narrowZ;
      SRC_WIDE_S:   opnd = wideS;
      SRC_WIDE_Z:   opnd = wideZ;
      SRC_WIDE_HI:  opnd = wideHi;
      default:      opnd = srcA;
    endcase
  end

  assign sum33    = {1'b0, srcB} + {1'b0, opnd};
  assign addSum   = sum33[DATA_W-1:0];
  assign addCarry = sum33[DATA_W];
  assign addOvf   = (srcB[MSB] == opnd[MSB]) && (addSum[MSB] != srcB[MSB]);

  assign mulRight = (ctrl.srcSel == SRC_REG) ? {{(DATA_W-HALF_W){1'b0}}, srcA[HALF_W-1:0]} : opnd;
  assign product  = {{(DATA_W-HALF_W){1'b0}}, srcB[HALF_W-1:0]} * mulRight;
  assign shamt    = opnd[SHAMT_W-1:0];

  always_comb begin
    case (ctrl.unit)
      UNIT_ADD:    result = addSum;
      UNIT_SUB_BA: result = srcB - opnd;
      UNIT_SUB_AB: result = opnd - srcB;
      UNIT_MUL:    result = product;
      UNIT_PASS:   result = opnd;
      UNIT_OR:     result = srcB | opnd;
      UNIT_AND:    result = srcB & opnd;
      UNIT_XOR:    result = srcB ^ opnd;
      UNIT_NOT:    result = ~opnd;
      UNIT_SAR:    result = $unsigned($signed(srcB) >>> shamt);
      UNIT_SHR:    result = srcB >> shamt;
      UNIT_SHL:    result = srcB << shamt;
      default:     result = '0;
    endcase
  end

  always_comb begin
    newFlag[FLAG_Z]  = (result == '0);
    newFlag[FLAG_S]  = result[MSB];
    newFlag[FLAG_OV] = ctrl.ovClear ? 1'b0 : addOvf;
    newFlag[FLAG_CY] = addCarry;
  end

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flagMerge
    assign flagsOut[i] = ctrl.flagWe[i] ? newFlag[i] : flagsIn[i];
  end

  always_comb begin
    // R3: carry agrees with an unsigned compare of sum against addends
    if (ctrl.unit == UNIT_ADD && ctrl.flagWe[FLAG_CY])
      a_r3_carry_compare: assert (flagsOut[FLAG_CY] == ((result < srcB) || (result < opnd)));
    // R3: sign flag follows the top result bit when written
    if (ctrl.flagWe[FLAG_S])
      a_r3_sign_msb: assert (flagsOut[FLAG_S] == result[MSB]);
    // R4: bitwise operations leave overflow low
    if (ctrl.ovClear)
      a_r4_ov_cleared: assert (!flagsOut[FLAG_OV]);
    // R10: no unit selected yields a zero result
    if (ctrl.unit == UNIT_NONE)
      a_r10_undef_zero: assert (result == '0);
    // R5: every unwritten flag passes through
    for (int i = 0; i < FLAG_N; i++) begin
      if (!ctrl.flagWe[i])
        a_r5_flag_hold: assert (flagsOut[i] == flagsIn[i]);
    end
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
(
  input  logic [OP_W-1:0]     opSel,
  input  logic [DATA_W-1:0]   srcA,
  input  logic [DATA_W-1:0]   srcB,
  input  logic [IMM_WIDE-1:0] imm,
  input  logic [FLAG_N-1:0]   flagsIn,
  output logic [DATA_W-1:0]   result,
  output logic [FLAG_N-1:0]   flagsOut,
  output logic [FLAG_N-1:0]   flagWe
);
  aluCtrl_t ctrl;

  int_alu_ctrl u_ctrl (
    .opSel (opSel),
    .ctrl  (ctrl)
  );

  int_alu_datapath u_datapath (
    .ctrl     (ctrl),
    .srcA     (srcA),
    .srcB     (srcB),
    .imm      (imm),
    .flagsIn  (flagsIn),
    .result   (result),
    .flagsOut (flagsOut)
  );

  assign flagWe = ctrl.flagWe;
endmodule

// File: tb/int_alu_bench.sv
`timescale 1ns/1ps
module int_alu_bench;
  logic        clk = 1'b0;
  logic [4:0]  opSel;
  logic [31:0] srcA, srcB, result;
  logic [15:0] imm;
  logic [3:0]  flagsIn, flagsOut, flagWe;
  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  int_alu u_int_alu (
    .opSel(opSel), .srcA(srcA), .srcB(srcB), .imm(imm), .flagsIn(flagsIn),
    .result(result), .flagsOut(flagsOut), .flagWe(flagWe)
  );

  logic [31:0] aList [12] = '{32'h0000_0001, 32'h0000_0001, 32'h0000_0000, 32'hFFFF_FFFF,
                              32'h8000_0000, 32'h0000_001F, 32'h0000_0000, 32'h0000_0013,
                              32'h0000_FFFF, 32'h8000_0010, 32'h7FFF_FFFF, 32'h0000_0004};
  logic [31:0] bList [12] = '{32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF,
                              32'h8000_0000, 32'h8000_0001, 32'h1234_5678, 32'hF0F0_F0F0,
                              32'h0000_FFFF, 32'hDEAD_BEEF, 32'h7FFF_FFFF, 32'h0000_0003};
  logic [15:0] immList [6] = '{16'h0000, 16'h0010, 16'h001F, 16'h800F, 16'h7FFF, 16'hFFE1};
  logic [3:0]  finList [3] = '{4'b0000, 4'b1111, 4'b1010};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s op=%0d a=%h b=%h imm=%h fin=%b actual=%h expected=%h",
               tag, opSel, srcA, srcB, imm, flagsIn, act, exp);
    end
  endtask

  function automatic logic [31:0] sarRef(input logic [31:0] v, input logic [4:0] s);
    return (v >> s) | (v[31] ? ~(32'hFFFF_FFFF >> s) : 32'd0);
  endfunction

  task automatic refModel(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                          input logic [15:0] im, input logic [3:0] fin,
                          output logic [31:0] r, output logic [3:0] fo, output logic [3:0] w,
                          output string rt, output string ft);
    logic [31:0] s5, s16, x;
    logic [63:0] wide;
    longint sv;
    int cls;
    logic cy, ov;
    s5  = {{27{im[4]}}, im[4:0]};
    s16 = {{16{im[15]}}, im};
    cls = 2; cy = 1'b0; ov = 1'b0; x = 32'd0;
    rt = "R10"; r = 32'd0;
    case (op)
      5'd0, 5'd1, 5'd2: begin
        x = (op == 5'd0) ? a : ((op == 5'd1) ? s5 : s16);
        r = b + x;
        wide = {32'd0, b} + {32'd0, x};
        cy = wide[32];
        sv = longint'($signed(b)) + longint'($signed(x));
        ov = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
        cls = 0; rt = (op == 5'd0) ? "R1" : "R2";
      end
      5'd3: begin r = b - a; rt = "R1"; end
      5'd4: begin r = a - b; rt = "R1"; end
      5'd5: begin r = {16'd0, b[15:0]} * {16'd0, a[15:0]}; rt = "R6"; end
      5'd6: begin sv = longint'(b[15:0]) * longint'($signed(s5)); r = sv[31:0]; rt = "R6"; end
      5'd7: begin r = {16'd0, b[15:0]} * {16'd0, im}; rt = "R6"; end
      5'd8: begin r = a; rt = "R7"; end
      5'd9: begin r = s5; rt = "R7"; end
      5'd10: begin r = b + s16; rt = "R7"; end
      5'd11: begin r = b + {im, 16'd0}; rt = "R7"; end
      5'd12: begin r = b | a; cls = 1; rt = "R8"; end
      5'd13: begin r = b | {16'd0, im}; cls = 1; rt = "R8"; end
      5'd14: begin r = b & a; cls = 1; rt = "R8"; end
      5'd15: begin r = b & {16'd0, im}; cls = 1; rt = "R8"; end
      5'd16: begin r = b ^ a; cls = 1; rt = "R8"; end
      5'd17: begin r = b ^ {16'd0, im}; cls = 1; rt = "R8"; end
      5'd18: begin r = ~a; cls = 1; rt = "R8"; end
      5'd19: begin r = sarRef(b, a[4:0]); rt = "R9"; end
      5'd20: begin r = sarRef(b, im[4:0]); rt = "R9"; end
      5'd21: begin r = b >> a[4:0]; rt = "R9"; end
      5'd22: begin r = b >> im[4:0]; rt = "R9"; end
      5'd23: begin r = b << a[4:0]; rt = "R9"; end
      5'd24: begin r = b << im[4:0]; rt = "R9"; end
      default: begin r = 32'd0; rt = "R10"; end
    endcase
    if (cls == 0) begin
      fo = {cy, ov, r[31], (r == 32'd0)}; w = 4'b1111; ft = "R3";
    end else if (cls == 1) begin
      fo = {fin[3], 1'b0, r[31], (r == 32'd0)}; w = 4'b0111; ft = "R4";
    end else begin
      fo = fin; w = 4'b0000; ft = "R5";
    end
  endtask

  task automatic applyAndCheck(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                               input logic [15:0] im, input logic [3:0] fin);
    logic [31:0] er;
    logic [3:0]  ef, ew;
    string rt, ft;
    @(negedge clk);
    opSel = op; srcA = a; srcB = b; imm = im; flagsIn = fin;
    refModel(op, a, b, im, fin, er, ef, ew, rt, ft);
    #5;
    check({rt, " result"}, result, er);
    check({ft, " flagsOut"}, {28'd0, flagsOut}, {28'd0, ef});
    check({ft, " flagWe"}, {28'd0, flagWe}, {28'd0, ew});
  endtask

  initial begin
    #3000000;
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    opSel = 5'd31; srcA = 32'd0; srcB = 32'd0; imm = 16'd0; flagsIn = 4'd0;
    // initial state: an undefined opcode yields zero result and no flag writes (R10, R5)
    applyAndCheck(5'd31, 32'h1234_5678, 32'h9ABC_DEF0, 16'hFFFF, 4'b1001);
    // named corner cases: R3 carry/overflow, R9 shift 0 and 31, R2 imm 0x10
    applyAndCheck(5'd0, 32'h0000_0001, 32'h7FFF_FFFF, 16'h0000, 4'b0000);
    applyAndCheck(5'd0, 32'h0000_0001, 32'hFFFF_FFFF, 16'h0000, 4'b0000);
    applyAndCheck(5'd19, 32'h0000_0000, 32'h8000_0001, 16'h0000, 4'b0101);
    applyAndCheck(5'd20, 32'h0000_0000, 32'h8000_0001, 16'h001F, 4'b0101);
    applyAndCheck(5'd1, 32'h0000_0000, 32'h0000_0020, 16'h0010, 4'b0000);
    // full sweep over every opcode
    for (int op = 0; op < 32; op++)
      for (int p = 0; p < 12; p++)
        for (int k = 0; k < 6; k++)
          for (int f = 0; f < 3; f++)
            applyAndCheck(op[4:0], aList[p], bList[p], immList[k], finList[f]);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule